// File: doc/BRIEF.md
# Sleep-to-Wake Sample Rate Controller

This block produces the sample strobes that pace a low-power sensor front end. A 400 Hz base tick is divided down to the rate that a set of host-written control fields selects: a 3-bit power-mode field, a 2-bit fast-rate field and a 2-bit wake-control field. Each strobe marks one produced sample. A companion flag tells downstream duration counters whether that strobe belongs to the fast rate or to a low-power rate.

The wake-control field lets the block sleep at a low-power rate while it waits for an interrupt event. When the event arrives, the hardware rewrites that field itself and sampling moves to the fast rate. The power-mode field keeps its stored value throughout. While the wake-control field is nonzero, the power-mode bits do not steer the rate. The live wake-control value is visible on an output port.

Host writes use one port: `wrAddr` 0 selects the power-mode field (`wrData[2:0]`), 1 selects the fast-rate field (`wrData[1:0]`), 2 selects the wake-control field (`wrData[1:0]`), and 3 is ignored.

Top module: `sleepwake_rate_ctrl`

## Requirements
- R1: After reset the power-mode field is 000, the fast-rate field is 00 and the wake-control field is 00. No strobe is produced. Selecting normal mode then gives one strobe every 8 base ticks.
- R2: With the wake-control field at 00, power mode 000 and 111 give no strobes. Mode 001 gives the fast rate. Modes 010, 011, 100, 101 and 110 give one strobe every 800, 400, 200, 80 and 40 base ticks respectively.
- R3: The fast rate divides the base tick by 8 for code 00, by 4 for code 01, by 1 for code 10, and by 8 for code 11.
- R4: With the wake-control field at 11 (armed), the rate is the low-power rate of the power-mode field. If that field holds no low-power code (000, 001, 111), the rate falls back to one strobe every 800 ticks.
- R5: An event while armed sets the wake-control field to 01, and the rate switches to the fast rate. The stored power mode is unchanged and applies again once the field is written back to 00.
- R6: An event while the wake-control field is 00 or 01 leaves the field unchanged.
- R7: While the wake-control field is 01, writing the power-mode field does not change the rate.
- R8: A host write of 10 to the wake-control field stores 00. The field never reads 10.
- R9: A host write to the wake-control field in the same cycle as an event takes priority over the event. An event that coincides with a write to another field still takes effect.
- R10: Whenever the selected rate (on/off, fast/low-power, divisor) changes, the divider restarts: the first strobe comes exactly one full divisor of ticks after the change. A write that leaves the rate unchanged does not restart it.
- R11: `sampleFast` is high together with a strobe produced at the fast rate, and low with a strobe produced at a low-power rate.
- R12: A strobe is a single-cycle pulse, one cycle after the base tick that completes the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baseTick | input | 1 | One-cycle pulse at 400 Hz |
| wrEn | input | 1 | Host write strobe |
| wrAddr | input | 2 | Field select: 0 power mode, 1 fast rate, 2 wake control |
| wrData | input | 3 | Write data (low bits used for 2-bit fields) |
| eventIn | input | 1 | Interrupt event pulse |
| sampleStrobe | output | 1 | One pulse per produced sample |
| sampleFast | output | 1 | High with a strobe produced at the fast rate |
| wakeCtl | output | 2 | Live wake-control field |

## Verification
A wrong wake-control state shows on `wakeCtl` one cycle after the write or event that caused it. It also shows as a change of strobe spacing at the next expected strobe. A divider that fails to restart, or restarts when it should not, shifts the phase of the first strobe after a write; the bench predicts that strobe to the exact tick. A wrong rate decode appears within one divisor period: at most 800 ticks for the slowest rate, and a single tick for the fastest.

// File: rtl/swr_pkg.sv
package swr_pkg;
  localparam int CNT_W = 10;

  localparam int DIV_F50   = 8;
  localparam int DIV_F100  = 4;
  localparam int DIV_F400  = 1;
  localparam int DIV_LP0P5 = 800;
  localparam int DIV_LP1   = 400;
  localparam int DIV_LP2   = 200;
  localparam int DIV_LP5   = 80;
  localparam int DIV_LP10  = 40;

  localparam logic [1:0] ADDR_PM = 2'd0;
  localparam logic [1:0] ADDR_FR = 2'd1;
  localparam logic [1:0] ADDR_WK = 2'd2;

  typedef enum logic [1:0] {
    WK_OFF   = 2'b00,
    WK_WOKEN = 2'b01,
    WK_BAD   = 2'b10,
    WK_ARMED = 2'b11
  } wake_e;

  typedef struct packed {
    logic             on;
    logic             fast;
    logic [CNT_W-1:0] div;
  } rate_sel_t;

  typedef struct packed {
    logic             restart;
    logic             run;
    logic             fast;
    logic [CNT_W-1:0] lastCnt;
  } div_ctl_t;
endpackage

// File: rtl/swr_ctrl.sv
module swr_ctrl
  import swr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] wrAddr,
  input  logic [2:0] wrData,
  input  logic       eventIn,
  output div_ctl_t   divCtl,
  output logic [1:0] wakeCtl,
  output logic [2:0] powerMode
);
  logic [2:0] pmReg;
  logic [1:0] frReg;
  wake_e      wkReg;
  logic       hostWake;
  rate_sel_t  curSel;
  rate_sel_t  prevSel;

  function automatic logic isLowPower(input logic [2:0] pm);
    return (pm >= 3'd2) && (pm <= 3'd6);
  endfunction

  function automatic logic [CNT_W-1:0] lowPowerDiv(input logic [2:0] pm);
    case (pm)
      3'd2:    return CNT_W'(DIV_LP0P5);
      3'd3:    return CNT_W'(DIV_LP1);
      3'd4:    return CNT_W'(DIV_LP2);
      3'd5:    return CNT_W'(DIV_LP5);
      3'd6:    return CNT_W'(DIV_LP10);
      default: return CNT_W'(DIV_LP0P5);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] fastDiv(input logic [1:0] fr);
    case (fr)
      2'd1:    return CNT_W'(DIV_F100);
      2'd2:    return CNT_W'(DIV_F400);
      default: return CNT_W'(DIV_F50);
    endcase
  endfunction

  assign hostWake = wrEn && (wrAddr == ADDR_WK);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pmReg <= 3'd0;
      frReg <= 2'd0;
      wkReg <= WK_OFF;
    end else begin
      if (wrEn && (wrAddr == ADDR_PM)) pmReg <= wrData;
      if (wrEn && (wrAddr == ADDR_FR)) frReg <= wrData[1:0];
      if (hostWake) begin
        wkReg <= (wrData[1:0] == WK_BAD) ? WK_OFF : wake_e'(wrData[1:0]);
      end else if (eventIn && (wkReg == WK_ARMED)) begin
        wkReg <= WK_WOKEN;
      end
    end
  end

  always_comb begin
    curSel = '0;
    case (wkReg)
      WK_WOKEN: begin
        curSel.on   = 1'b1;
        curSel.fast = 1'b1;
        curSel.div  = fastDiv(frReg);
      end
      WK_ARMED: begin
        curSel.on  = 1'b1;
        curSel.div = lowPowerDiv(pmReg);
      end
      default: begin
        if (pmReg == 3'd1) begin
          curSel.on   = 1'b1;
          curSel.fast = 1'b1;
          curSel.div  = fastDiv(frReg);
        end else if (isLowPower(pmReg)) begin
          curSel.on  = 1'b1;
          curSel.div = lowPowerDiv(pmReg);
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) prevSel <= '0;
    else       prevSel <= curSel;
  end

  always_comb begin
    divCtl.restart = (curSel != prevSel);
    divCtl.run     = curSel.on;
    divCtl.fast    = curSel.fast;
    divCtl.lastCnt = curSel.div - CNT_W'(1);
  end

  assign wakeCtl   = wkReg;
  assign powerMode = pmReg;
endmodule

// File: rtl/swr_divider.sv
module swr_divider
  import swr_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     baseTick,
  input  div_ctl_t divCtl,
  output logic     sampleStrobe,
  output logic     sampleFast
);
  logic [CNT_W-1:0] tickCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt      <= '0;
      sampleStrobe <= 1'b0;
      sampleFast   <= 1'b0;
    end else begin
      sampleStrobe <= 1'b0;
      sampleFast   <= 1'b0;
      if (divCtl.restart || !divCtl.run) begin
        tickCnt <= '0;
      end else if (baseTick) begin
        if (tickCnt >= divCtl.lastCnt) begin
          tickCnt      <= '0;
          sampleStrobe <= 1'b1;
          sampleFast   <= divCtl.fast;
        end else begin
          tickCnt <= tickCnt + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/sleepwake_rate_ctrl.sv
module sleepwake_rate_ctrl
  import swr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       baseTick,
  input  logic       wrEn,
  input  logic [1:0] wrAddr,
  input  logic [2:0] wrData,
  input  logic       eventIn,
  output logic       sampleStrobe,
  output logic       sampleFast,
  output logic [1:0] wakeCtl
);
  div_ctl_t   divCtl;
  logic [2:0] cfgPowerMode;

  swr_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .eventIn   (eventIn),
    .divCtl    (divCtl),
    .wakeCtl   (wakeCtl),
    .powerMode (cfgPowerMode)
  );

  swr_divider u_div (
    .clk          (clk),
    .rstN         (rstN),
    .baseTick     (baseTick),
    .divCtl       (divCtl),
    .sampleStrobe (sampleStrobe),
    .sampleFast   (sampleFast)
  );
endmodule

// File: rtl/swr_checker.sv
module swr_checker (
  input logic       clk,
  input logic       rstN,
  input logic       baseTick,
  input logic       wrEn,
  input logic [1:0] wrAddr,
  input logic [2:0] wrData,
  input logic       eventIn,
  input logic       sampleStrobe,
  input logic       sampleFast,
  input logic [1:0] wakeCtl,
  input logic [2:0] cfgPowerMode
);
  logic wakeWrite;
  assign wakeWrite = wrEn && (wrAddr == 2'd2);

  a_r12_strobe_follows_tick: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe |-> $past(baseTick));

  a_r8_never_reserved: assert property (@(posedge clk) disable iff (!rstN)
    wakeCtl != 2'b10);

  a_r8_reserved_write_clears: assert property (@(posedge clk) disable iff (!rstN)
    (wakeWrite && wrData[1:0] == 2'b10) |=> (wakeCtl == 2'b00));

  a_r5_event_wakes: assert property (@(posedge clk) disable iff (!rstN)
    (wakeCtl == 2'b11 && eventIn && !wakeWrite) |=> (wakeCtl == 2'b01));

  a_r9_host_wins: assert property (@(posedge clk) disable iff (!rstN)
    (wakeWrite && wrData[1:0] == 2'b11) |=> (wakeCtl == 2'b11));

  a_r6_no_spurious_change: assert property (@(posedge clk) disable iff (!rstN)
    (wakeCtl != 2'b11 && !wakeWrite) |=> $stable(wakeCtl));

  a_r11_woken_is_fast: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStrobe && $past(wakeCtl) == 2'b01) |-> sampleFast);

  a_r2_powerdown_silent: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe |-> !($past(wakeCtl) == 2'b00 && $past(cfgPowerMode) == 3'd0));
endmodule

bind sleepwake_rate_ctrl swr_checker u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .baseTick     (baseTick),
  .wrEn         (wrEn),
  .wrAddr       (wrAddr),
  .wrData       (wrData),
  .eventIn      (eventIn),
  .sampleStrobe (sampleStrobe),
  .sampleFast   (sampleFast),
  .wakeCtl      (wakeCtl),
  .cfgPowerMode (cfgPowerMode)
);

// File: tb/sleepwake_rate_ctrl_tb.sv
module sleepwake_rate_ctrl_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baseTick = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = 2'd0;
  logic [2:0] wrData = 3'd0;
  logic       eventIn = 1'b0;
  logic       sampleStrobe;
  logic       sampleFast;
  logic [1:0] wakeCtl;

  int testCount = 0;
  int failCount = 0;

  logic [2:0]  mPm = 3'd0;
  logic [1:0]  mFr = 2'd0;
  logic [1:0]  mWk = 2'd0;
  logic [11:0] mSel = '0;
  int          mCnt = 0;

  always #10 clk = ~clk;

  sleepwake_rate_ctrl u_dut (
    .clk(clk), .rstN(rstN), .baseTick(baseTick), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .eventIn(eventIn), .sampleStrobe(sampleStrobe),
    .sampleFast(sampleFast), .wakeCtl(wakeCtl)
  );

  function automatic int expFastDiv(input logic [1:0] fr);
    if (fr == 2'd1) return 4;
    if (fr == 2'd2) return 1;
    return 8;
  endfunction

  function automatic int expLpDiv(input logic [2:0] pm);
    case (pm)
      3'd3: return 400;
      3'd4: return 200;
      3'd5: return 80;
      3'd6: return 40;
      default: return 800;
    endcase
  endfunction

  // {on, fast, divisor}
  function automatic logic [11:0] expSel();
    logic lp;
    lp = (mPm >= 3'd2) && (mPm <= 3'd6);
    if (mWk == 2'b01) return {1'b1, 1'b1, 10'(expFastDiv(mFr))};
    if (mWk == 2'b11) return {1'b1, 1'b0, 10'(expLpDiv(mPm))};
    if (mPm == 3'd1)  return {1'b1, 1'b1, 10'(expFastDiv(mFr))};
    if (lp)           return {1'b1, 1'b0, 10'(expLpDiv(mPm))};
    return '0;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic op(input logic doW, input logic [1:0] a, input logic [2:0] d,
                    input logic doEv, input string tag);
    logic [11:0] ns;
    @(negedge clk);
    wrEn = doW; wrAddr = a; wrData = d; eventIn = doEv;
    @(negedge clk);
    wrEn = 1'b0; eventIn = 1'b0;
    if (doW && a == 2'd0) mPm = d;
    if (doW && a == 2'd1) mFr = d[1:0];
    if (doW && a == 2'd2) mWk = (d[1:0] == 2'b10) ? 2'b00 : d[1:0];
    else if (doEv && mWk == 2'b11) mWk = 2'b01;
    check(tag, 16'(wakeCtl), 16'(mWk));
    ns = expSel();
    if (ns != mSel) mCnt = 0;
    mSel = ns;
    @(negedge clk);
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      logic expS, expF;
      baseTick = 1'b1;
      @(negedge clk);
      baseTick = 1'b0;
      expS = 1'b0;
      if (mSel[11]) begin
        mCnt++;
        if (mCnt == int'(mSel[9:0])) begin
          expS = 1'b1;
          mCnt = 0;
        end
      end
      expF = expS && mSel[10];
      check({tag, " R12 strobe"}, 16'(sampleStrobe), 16'(expS));
      check({tag, " R11 fast flag"}, 16'(sampleFast), 16'(expF));
      @(negedge clk);
      check({tag, " R12 single pulse"}, 16'(sampleStrobe), 16'd0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    void'($urandom(32'd4021));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 wake after reset", 16'(wakeCtl), 16'd0);
    check("R1 strobe after reset", 16'(sampleStrobe), 16'd0);
    ticks(20, "R1 powerdown");
    op(1, 2'd0, 3'd1, 0, "R1");
    ticks(17, "R1 default 50Hz");
    // R3 fast codes
    op(1, 2'd1, 3'd1, 0, "R3"); ticks(9, "R3 div4");
    op(1, 2'd1, 3'd2, 0, "R3"); ticks(5, "R3 div1");
    op(1, 2'd1, 3'd3, 0, "R3"); ticks(17, "R3 code11");
    // R10 restart and no-restart
    op(1, 2'd1, 3'd0, 0, "R10"); ticks(5, "R10 pre");
    op(1, 2'd1, 3'd1, 0, "R10"); ticks(3, "R10 post");
    op(1, 2'd1, 3'd1, 0, "R10 same"); ticks(6, "R10 norestart");
    // R2 all power-mode codes
    for (int pm = 2; pm <= 6; pm++) begin
      op(1, 2'd0, 3'(pm), 0, "R2");
      ticks(expLpDiv(3'(pm)) + 3, "R2 lowpower");
    end
    op(1, 2'd0, 3'd7, 0, "R2"); ticks(50, "R2 code111");
    op(1, 2'd0, 3'd0, 0, "R2"); ticks(20, "R2 code000");
    // R4 armed
    op(1, 2'd0, 3'd6, 0, "R4");
    op(1, 2'd2, 3'd3, 0, "R4 arm"); ticks(85, "R4 armed lp");
    op(1, 2'd0, 3'd1, 0, "R4"); ticks(805, "R4 fallback");
    // R5 event
    op(1, 2'd0, 3'd6, 0, "R5");
    op(0, 2'd0, 3'd0, 1, "R5 event"); ticks(20, "R5 fast");
    // R6 event while woken, R7 pm ignored
    op(0, 2'd0, 3'd0, 1, "R6 woken event");
    op(1, 2'd0, 3'd0, 0, "R7"); ticks(20, "R7 pm ignored");
    op(1, 2'd0, 3'd6, 0, "R5");
    op(1, 2'd2, 3'd0, 0, "R5 release"); ticks(45, "R5 pm kept");
    op(0, 2'd0, 3'd0, 1, "R6 off event"); ticks(5, "R6");
    // R8 reserved
    op(1, 2'd2, 3'd3, 0, "R8");
    op(1, 2'd2, 3'd2, 0, "R8 reserved write"); ticks(5, "R8");
    // R9 priority
    op(1, 2'd2, 3'd3, 0, "R9");
    op(1, 2'd2, 3'd3, 1, "R9 host wins");
    op(1, 2'd1, 3'd2, 1, "R9 other field"); ticks(6, "R9");
    // random mix
    for (int k = 0; k < 120; k++) begin
      logic [1:0] a;
      a = 2'($urandom % 4);
      op(1'($urandom % 3 != 0), a, 3'($urandom % 8), 1'($urandom % 3 == 0), "R10 random");
      ticks(1 + ($urandom % 200), "random");
    end
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule